// File: doc/BRIEF.md
# Sliding-Window Linear Score Accumulator

This block is the linear-classifier stage of a pedestrian detector that works on histogram-of-gradient features. Feature blocks arrive one at a time in raster order. Each block carries 36 unsigned 9-bit elements and its block row and column in the frame. The detection window is 7 blocks wide and 15 blocks tall and moves in steps of one block. Each incoming block therefore belongs to up to 105 windows.

On each cycle the block visits one of those windows. It is multiplied by the 36-weight slice that matches its position inside that window, and the 36 products are reduced to one partial sum. The partial sum is folded into the window's running total, which lives in an on-chip slot RAM together with a contribution count. When the count reaches 105, the block adds a bias and emits a 12-bit signed confidence, a one-cycle strobe and the window's row and column. Any later stage can threshold this confidence.

The slot RAM holds only as many running totals as can be open at once. Window row `wy` maps to slot row `wy mod 15`. A slot's count returns to zero when its window completes, so a later window can reuse the slot. The weight store can be rewritten through a load port when the trained model changes.

Top module: `svm_window_scorer`

## Requirements
- R1: After reset, `in_ready` is 1 and `score_valid` is 0.
- R2: A block is taken on a clock edge where `in_valid` and `in_ready` are both 1. After that edge, `in_ready` reads 0 for exactly N cycles, where N is the number of windows containing the block. N is the number of window rows in [max(0,row-14), min(row,NWY-1)] times the number of window columns in [max(0,col-6), min(col,NWX-1)]. NWX is FRAME_BW-6 and NWY is FRAME_BH-14.
- R3: For a block at (row,col) in window (wy,wx), the weight slice index is (row-wy)*7+(col-wx). Element i uses bits [9i+8:9i] of `in_data` and bits [10i+9:10i] of slice word `wt_wr_data`. Each weight is a two's-complement value with 8 fractional bits. The partial sum is floor(sum of element*weight / 256), clamped to [-2048, 2047].
- R4: A window's first contribution is stored as it is. Each later contribution is added with clamping to [-2048, 2047]. After the 105th contribution, the emitted score is clamp(total + BIAS).
- R5: `score_valid` is a single-cycle pulse. It appears after the block that completes the window has been taken, and no later than the cycle in which `in_ready` returns to 1.
- R6: Scores saturate at 2047 and -2048 when the products overflow, both in the running total and when the bias is added.
- R7: Writing slice k through `wt_wr_en`/`wt_wr_addr`/`wt_wr_data` replaces that slice for every contribution processed afterwards.
- R8: Only 15*NWX slots exist. Window rows at and beyond 15 reuse the slots of completed windows, and their scores stay correct across frames.
- R9: Every window in the frame is emitted exactly once, in raster order. Its (`score_row`, `score_col`) are the window's block coordinates. It is emitted while the block at (row+14, col+6) is being processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Feature block offered |
| in_ready | output | 1 | Block can be taken; low while scattering |
| in_row | input | ROW_W | Block row in the frame |
| in_col | input | COL_W | Block column in the frame |
| in_data | input | 324 | 36 unsigned 9-bit elements |
| wt_wr_en | input | 1 | Write one weight slice |
| wt_wr_addr | input | 7 | Slice index 0..104 |
| wt_wr_data | input | 360 | 36 signed 10-bit weights |
| score_valid | output | 1 | Confidence strobe |
| score_row | output | ROW_W | Window row |
| score_col | output | COL_W | Window column |
| score | output | 12 | Signed confidence |

## Verification
A wrong slot index or a stale count does not show when it happens. It appears only when the affected window completes: as a wrong score, a missing strobe or an extra strobe, up to fifteen block rows later. For that reason the bench runs whole frames, where window rows wrap onto reused slots, and compares every emitted coordinate and score with a model. An error in the scatter range control shows at once, in the number of cycles `in_ready` stays low for each block. A weight slice addressing error shows in the score of the first window that completes afterwards.

// File: rtl/svm_score_pkg.sv
// Shared constants, types and the clamp helper for the window scorer.
// Assumes fixed feature geometry: 36 elements per block and 7x15 blocks per window.
package svm_score_pkg;
    localparam int ELEMS      = 36;
    localparam int ELEM_W     = 9;
    localparam int WT_W       = 10;
    localparam int WT_FRAC    = 8;
    localparam int SUM_W      = 12;
    localparam int CNT_W      = 7;
    localparam int WIN_BW     = 7;
    localparam int WIN_BH     = 15;
    localparam int WIN_BLOCKS = WIN_BW * WIN_BH;
    localparam int SLICE_AW   = $clog2(WIN_BLOCKS);
    localparam int BLK_DW     = ELEMS * ELEM_W;
    localparam int SLICE_DW   = ELEMS * WT_W;
    localparam int SCORE_MAX  = (1 << (SUM_W - 1)) - 1;
    localparam int SCORE_MIN  = -(1 << (SUM_W - 1));

    typedef logic signed [SUM_W-1:0] score_t;

    typedef struct packed {
        score_t           sum;
        logic [CNT_W-1:0] cnt;
    } slot_word_t;

    // Clamp a wide signed value into the score range.
    function automatic score_t clamp_score(input logic signed [31:0] v);
        if (v > SCORE_MAX)      return score_t'(SCORE_MAX);
        else if (v < SCORE_MIN) return score_t'(SCORE_MIN);
        else                    return v[SUM_W-1:0];
    endfunction
endpackage

// File: rtl/svm_weight_store.sv
// Weight slice store: one 36-weight word per block position inside a window.
// Written through a load port; read combinationally. Not reset; the contents must be loaded before use.
module svm_weight_store
    import svm_score_pkg::*;
(
    input  logic                clk,
    input  logic                wr_en,
    input  logic [SLICE_AW-1:0] wr_addr,
    input  logic [SLICE_DW-1:0] wr_data,
    input  logic [SLICE_AW-1:0] rd_addr,
    output logic [SLICE_DW-1:0] rd_data
);
    logic [SLICE_DW-1:0] mem [WIN_BLOCKS];

    // Load one slice per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/svm_dot36.sv
// One-cycle dot product of a feature block with a weight slice.
// The result is rescaled by flooring away the fractional weight bits, then clamped.
module svm_dot36
    import svm_score_pkg::*;
(
    input  logic [BLK_DW-1:0]   blk,
    input  logic [SLICE_DW-1:0] wts,
    output score_t              partial
);
    localparam int PROD_W = ELEM_W + WT_W + 1;

    logic signed [PROD_W-1:0] prod [ELEMS];
    logic signed [31:0]       total;
    logic signed [31:0]       scaled;

    for (genvar g = 0; g < ELEMS; g++) begin : g_mul
        assign prod[g] = $signed({1'b0, blk[g*ELEM_W +: ELEM_W]}) * $signed(wts[g*WT_W +: WT_W]);
    end

    // Reduce the 36 products to one sum.
    always_comb begin
        total = '0;
        for (int i = 0; i < ELEMS; i++) total = total + 32'(prod[i]);
    end

    assign scaled  = total >>> WT_FRAC;
    assign partial = clamp_score(scaled);
endmodule

// File: rtl/svm_slot_ram.sv
// Running-total slot RAM with combinational read and synchronous write.
// Reset clears every word so that all contribution counts start at zero.
module svm_slot_ram #(
    parameter int DEPTH = 60,
    parameter int AW    = 6,
    parameter int DW    = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    // Clear on reset, otherwise write back the updated word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/svm_scatter_ctrl.sv
// Takes one block and walks every window containing it, one window per cycle,
// in raster order (row-major, low to high). Produces the slice index and the slot index.
// Assumes blocks arrive in raster order and their coordinates lie inside the frame.
module svm_scatter_ctrl
    import svm_score_pkg::*;
#(
    parameter int FRAME_BW = 10,
    parameter int FRAME_BH = 32,
    parameter int ROW_W    = 5,
    parameter int COL_W    = 4,
    parameter int SLOT_W   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [ROW_W-1:0]    in_row,
    input  logic [COL_W-1:0]    in_col,
    input  logic [BLK_DW-1:0]   in_data,
    output logic                visit,
    output logic [ROW_W-1:0]    win_row,
    output logic [COL_W-1:0]    win_col,
    output logic [SLICE_AW-1:0] slice_addr,
    output logic [SLOT_W-1:0]   slot,
    output logic [BLK_DW-1:0]   blk_q
);
    localparam int NWX = FRAME_BW - WIN_BW + 1;
    localparam int NWY = FRAME_BH - WIN_BH + 1;

    logic             busy_q;
    logic [ROW_W-1:0] br_q, wy_q, wy_hi_q;
    logic [COL_W-1:0] bc_q, wx_q, wx_lo_q, wx_hi_q;
    int               y_lo, y_hi, x_lo, x_hi;
    logic [ROW_W-1:0] dy;
    logic [COL_W-1:0] dx;

    // Range of windows that contain the offered block.
    always_comb begin
        y_lo = (int'(in_row) >= WIN_BH - 1) ? int'(in_row) - (WIN_BH - 1) : 0;
        y_hi = (int'(in_row) < NWY) ? int'(in_row) : NWY - 1;
        x_lo = (int'(in_col) >= WIN_BW - 1) ? int'(in_col) - (WIN_BW - 1) : 0;
        x_hi = (int'(in_col) < NWX) ? int'(in_col) : NWX - 1;
    end

    // Accept a block when idle, then step through its windows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            br_q    <= '0;
            bc_q    <= '0;
            wy_q    <= '0;
            wx_q    <= '0;
            wy_hi_q <= '0;
            wx_lo_q <= '0;
            wx_hi_q <= '0;
            blk_q   <= '0;
        end else if (!busy_q) begin
            if (in_valid) begin
                busy_q  <= 1'b1;
                br_q    <= in_row;
                bc_q    <= in_col;
                blk_q   <= in_data;
                wy_q    <= ROW_W'(y_lo);
                wy_hi_q <= ROW_W'(y_hi);
                wx_q    <= COL_W'(x_lo);
                wx_lo_q <= COL_W'(x_lo);
                wx_hi_q <= COL_W'(x_hi);
            end
        end else if (wx_q == wx_hi_q) begin
            if (wy_q == wy_hi_q) begin
                busy_q <= 1'b0;
            end else begin
                wy_q <= wy_q + 1'b1;
                wx_q <= wx_lo_q;
            end
        end else begin
            wx_q <= wx_q + 1'b1;
        end
    end

    assign dy         = br_q - wy_q;
    assign dx         = bc_q - wx_q;
    assign in_ready   = !busy_q;
    assign visit      = busy_q;
    assign win_row    = wy_q;
    assign win_col    = wx_q;
    assign slice_addr = SLICE_AW'(int'(dy) * WIN_BW + int'(dx));
    assign slot       = SLOT_W'((int'(wy_q) % WIN_BH) * NWX + int'(wx_q));
endmodule

// File: rtl/svm_window_scorer.sv
// Top of the window scorer. Each visited window gets one read-modify-write of its slot.
// The first contribution replaces the stored sum. The 105th contribution emits a biased
// score and frees the slot by writing a zero count.
module svm_window_scorer
    import svm_score_pkg::*;
#(
    parameter int FRAME_BW = 10,
    parameter int FRAME_BH = 32,
    parameter int BIAS     = -37,
    localparam int ROW_W   = $clog2(FRAME_BH),
    localparam int COL_W   = $clog2(FRAME_BW)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [ROW_W-1:0]    in_row,
    input  logic [COL_W-1:0]    in_col,
    input  logic [BLK_DW-1:0]   in_data,
    input  logic                wt_wr_en,
    input  logic [SLICE_AW-1:0] wt_wr_addr,
    input  logic [SLICE_DW-1:0] wt_wr_data,
    output logic                score_valid,
    output logic [ROW_W-1:0]    score_row,
    output logic [COL_W-1:0]    score_col,
    output logic [SUM_W-1:0]    score
);
    localparam int NWX    = FRAME_BW - WIN_BW + 1;
    localparam int NSLOT  = WIN_BH * NWX;
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int WORD_W = $bits(slot_word_t);

    logic                visit;
    logic [ROW_W-1:0]    win_row;
    logic [COL_W-1:0]    win_col;
    logic [SLICE_AW-1:0] slice_addr;
    logic [SLOT_W-1:0]   slot;
    logic [BLK_DW-1:0]   blk_q;
    logic [SLICE_DW-1:0] slice;
    score_t              partial;
    slot_word_t          old_word, new_word;
    logic [WORD_W-1:0]   rd_bits;
    score_t              acc;
    logic [CNT_W-1:0]    next_cnt;
    logic                win_done;

    svm_scatter_ctrl #(
        .FRAME_BW(FRAME_BW), .FRAME_BH(FRAME_BH),
        .ROW_W(ROW_W), .COL_W(COL_W), .SLOT_W(SLOT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_row(in_row), .in_col(in_col), .in_data(in_data),
        .visit(visit), .win_row(win_row), .win_col(win_col),
        .slice_addr(slice_addr), .slot(slot), .blk_q(blk_q)
    );

    svm_weight_store u_wts (
        .clk(clk), .wr_en(wt_wr_en), .wr_addr(wt_wr_addr), .wr_data(wt_wr_data),
        .rd_addr(slice_addr), .rd_data(slice)
    );

    svm_dot36 u_dot (.blk(blk_q), .wts(slice), .partial(partial));

    svm_slot_ram #(.DEPTH(NSLOT), .AW(SLOT_W), .DW(WORD_W)) u_slots (
        .clk(clk), .rst_n(rst_n), .wr_en(visit), .wr_addr(slot), .wr_data(new_word),
        .rd_addr(slot), .rd_data(rd_bits)
    );

    // Fold the partial sum into the slot and detect window completion.
    always_comb begin
        old_word     = slot_word_t'(rd_bits);
        next_cnt     = old_word.cnt + 1'b1;
        acc          = (old_word.cnt == '0) ? partial
                                             : clamp_score(32'(old_word.sum) + 32'(partial));
        win_done     = (next_cnt == CNT_W'(WIN_BLOCKS));
        new_word.sum = acc;
        new_word.cnt = win_done ? '0 : next_cnt;
    end

    // Register the biased score of a completed window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            score_valid <= 1'b0;
            score_row   <= '0;
            score_col   <= '0;
            score       <= '0;
        end else begin
            score_valid <= visit && win_done;
            if (visit && win_done) begin
                score     <= clamp_score(32'(acc) + BIAS);
                score_row <= win_row;
                score_col <= win_col;
            end
        end
    end
endmodule

// File: rtl/svm_window_scorer_chk.sv
// Port-level properties of the window scorer, bound to every instance of the top.
module svm_window_scorer_chk #(
    parameter int NWX   = 4,
    parameter int NWY   = 18,
    parameter int ROW_W = 5,
    parameter int COL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             score_valid,
    input logic [ROW_W-1:0] score_row,
    input logic [COL_W-1:0] score_col
);
    // R2
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R5
    score_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        score_valid |=> !score_valid);

    // R5
    score_after_scatter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        score_valid |-> $past(!in_ready));

    // R9
    score_coord_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        score_valid |-> (int'(score_row) < NWY && int'(score_col) < NWX));
endmodule

bind svm_window_scorer svm_window_scorer_chk #(
    .NWX(FRAME_BW - svm_score_pkg::WIN_BW + 1),
    .NWY(FRAME_BH - svm_score_pkg::WIN_BH + 1),
    .ROW_W(ROW_W),
    .COL_W(COL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .score_valid(score_valid), .score_row(score_row), .score_col(score_col)
);

// File: tb/tb_svm_window_scorer.sv
`timescale 1ns/1ps
module tb_svm_window_scorer;
    import svm_score_pkg::*;

    localparam int FBW  = 10;
    localparam int FBH  = 32;
    localparam int BIAS = -37;
    localparam int RW   = $clog2(FBH);
    localparam int CW   = $clog2(FBW);
    localparam int NWX  = FBW - WIN_BW + 1;
    localparam int NWY  = FBH - WIN_BH + 1;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                in_valid;
    logic                in_ready;
    logic [RW-1:0]       in_row;
    logic [CW-1:0]       in_col;
    logic [BLK_DW-1:0]   in_data;
    logic                wt_wr_en;
    logic [SLICE_AW-1:0] wt_wr_addr;
    logic [SLICE_DW-1:0] wt_wr_data;
    logic                score_valid;
    logic [RW-1:0]       score_row;
    logic [CW-1:0]       score_col;
    logic [SUM_W-1:0]    score;

    always #4 clk = ~clk;

    svm_window_scorer #(.FRAME_BW(FBW), .FRAME_BH(FBH), .BIAS(BIAS)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_row(in_row), .in_col(in_col), .in_data(in_data),
        .wt_wr_en(wt_wr_en), .wt_wr_addr(wt_wr_addr), .wt_wr_data(wt_wr_data),
        .score_valid(score_valid), .score_row(score_row), .score_col(score_col),
        .score(score)
    );

    int    wb [WIN_BLOCKS][ELEMS];
    int    m_sum [NWY][NWX];
    int    m_cnt [NWY][NWX];
    int    exp_r[$], exp_c[$], exp_s[$];
    int    n_chk = 0, n_fail = 0;
    string req_tag = "R3";
    bit    finished = 1'b0;
    bit    prev_valid = 1'b0;
    int    er, ec, es;

    function automatic int clampv(int v);
        if (v > 2047)  return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // Compare each emitted score with the model queue (R9, R5, plus the frame's tag).
    always @(negedge clk) begin
        if (rst_n && score_valid) begin
            check("R5", int'(prev_valid), 0, "strobe width");
            if (exp_r.size() == 0) begin
                check("R9", 1, 0, "unexpected window strobe");
            end else begin
                er = exp_r.pop_front();
                ec = exp_c.pop_front();
                es = exp_s.pop_front();
                check("R9", int'(score_row), er, "window row");
                check("R9", int'(score_col), ec, "window col");
                check(req_tag, int'($signed(score)), es, "score");
            end
        end
        prev_valid = rst_n && score_valid;
    end

    // Weight modes: 0 small random, 1 all +511, 2 all -512.
    task automatic load_weights(int mode);
        for (int k = 0; k < WIN_BLOCKS; k++) begin
            logic [SLICE_DW-1:0] vec;
            for (int i = 0; i < ELEMS; i++) begin
                int w;
                w = (mode == 0) ? int'($urandom_range(0, 16)) - 8 : (mode == 1) ? 511 : -512;
                wb[k][i] = w;
                vec[i*WT_W +: WT_W] = w[WT_W-1:0];
            end
            @(negedge clk);
            wt_wr_en   = 1'b1;
            wt_wr_addr = SLICE_AW'(k);
            wt_wr_data = vec;
        end
        @(negedge clk);
        wt_wr_en = 1'b0;
    endtask

    // Element modes: 0 random, 1 all 511, 2 all zero.
    task automatic send_block(int r, int c, int mode);
        int el [ELEMS];
        logic [BLK_DW-1:0] vec;
        int nwin, busy, ylo, yhi, xlo, xhi;
        for (int i = 0; i < ELEMS; i++) begin
            el[i] = (mode == 0) ? int'($urandom_range(0, 511)) : (mode == 1) ? 511 : 0;
            vec[i*ELEM_W +: ELEM_W] = el[i][ELEM_W-1:0];
        end
        ylo = (r >= 14) ? r - 14 : 0;
        yhi = (r < NWY) ? r : NWY - 1;
        xlo = (c >= 6) ? c - 6 : 0;
        xhi = (c < NWX) ? c : NWX - 1;
        nwin = 0;
        for (int wy = ylo; wy <= yhi; wy++) begin
            for (int wx = xlo; wx <= xhi; wx++) begin
                int p, k;
                nwin++;
                k = (r - wy) * 7 + (c - wx);
                p = 0;
                for (int i = 0; i < ELEMS; i++) p += el[i] * wb[k][i];
                p = clampv(p >>> 8);
                m_sum[wy][wx] = (m_cnt[wy][wx] == 0) ? p : clampv(m_sum[wy][wx] + p);
                m_cnt[wy][wx]++;
                if (m_cnt[wy][wx] == 105) begin
                    exp_r.push_back(wy);
                    exp_c.push_back(wx);
                    exp_s.push_back(clampv(m_sum[wy][wx] + BIAS));
                    m_cnt[wy][wx] = 0;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_row   = RW'(r);
        in_col   = CW'(c);
        in_data  = vec;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        busy = 0;
        while (!in_ready) begin
            busy++;
            @(negedge clk);
        end
        check("R2", busy, nwin, $sformatf("busy cycles of block (%0d,%0d)", r, c));
    endtask

    task automatic run_frame(int mode);
        for (int r = 0; r < FBH; r++)
            for (int c = 0; c < FBW; c++)
                send_block(r, c, mode);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check("WDOG", 1, 0, "watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7321));
        for (int y = 0; y < NWY; y++)
            for (int x = 0; x < NWX; x++) begin
                m_sum[y][x] = 0;
                m_cnt[y][x] = 0;
            end
        rst_n = 1'b0; in_valid = 1'b0; in_row = '0; in_col = '0; in_data = '0;
        wt_wr_en = 1'b0; wt_wr_addr = '0; wt_wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(in_ready), 1, "ready after reset");
        check("R1", int'(score_valid), 0, "strobe after reset");

        load_weights(0);
        req_tag = "R3";
        run_frame(0);          // random data, window rows wrap onto reused slots
        req_tag = "R8";
        run_frame(0);          // second frame on recycled slots
        load_weights(1);
        req_tag = "R6";
        run_frame(1);          // positive saturation
        load_weights(2);
        req_tag = "R7";
        run_frame(1);          // reloaded model, negative saturation through bias
        req_tag = "R4";
        run_frame(2);          // zero data: score equals bias

        repeat (4) @(negedge clk);
        check("R9", exp_r.size(), 0, "windows never emitted");
        finish_run();
    end
endmodule